// File: doc/BRIEF.md
# Cascadable Presettable Up/Down Counter

This block is a synchronous binary counter of parametric width (8 bits by default). It is clocked on the rising edge. A two-bit operation select picks one of four actions: clear, count down, parallel load or count up. Clear and load happen on the clock edge whatever the enables are doing. The two count modes advance only when both active-low enables are low. All count bits change on the same edge, and a change on any control input has no effect on the count until that edge.

An active-low carry output flags the terminal count for the direction currently selected. It flags all-zeros when counting down and all-ones when counting up. The carry is combinational and is qualified only by the trickle enable. A stage's carry can therefore drive the trickle enable of the next stage, and identical stages chain into a wider synchronous counter with no glue logic. The parallel enable, the operation select and the clock are shared by every stage of the chain.

A reset input is present for simulation start-up only. It forces the count to zero.

Top module: `updn_cascade_ctr`

## Requirements
- R1: While `rst_n` is low the count is zero.
- R2: With `op_sel` = 2'b00 (clear), the count becomes zero on the next rising edge, whatever the levels of both enables.
- R3: With `op_sel` = 2'b10 (load), the count takes the value of `load_val` on the next rising edge, whatever the levels of both enables.
- R4: With `op_sel` = 2'b11 (up), and with `en_par_n` and `en_trk_n` both low, the count increases by one on each rising edge. It wraps from all-ones to zero.
- R5: With `op_sel` = 2'b01 (down), and with both enables low, the count decreases by one on each rising edge. It wraps from zero to all-ones.
- R6: In either count mode, when `en_par_n` or `en_trk_n` is high, the count holds its value across the edge.
- R7: `carry_n` is low exactly when all three of these hold: `en_trk_n` is low, a count mode is selected, and the count is at that mode's terminal value (zero for down, all-ones for up). Otherwise `carry_n` is high, and it is always high while `en_trk_n` is high.
- R8: A change on `op_sel`, `load_val` or either enable between edges leaves the count unchanged until the next rising edge.
- R9: Two stages, with the low stage's `carry_n` driving the high stage's `en_trk_n`, behave as a single counter of twice the width that obeys R2 to R7.
- R10: The width is set by parameter `WIDTH`, and the wrap points and the carry terminal values follow from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset for simulation start-up; clears the count |
| op_sel | input | 2 | Operation: 00 clear, 01 down, 10 load, 11 up |
| en_par_n | input | 1 | Active-low parallel count enable |
| en_trk_n | input | 1 | Active-low trickle enable; also qualifies the carry |
| load_val | input | WIDTH | Value taken in load mode |
| count_q | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low terminal-count carry |

## Verification
The bench builds two stages with `WIDTH` = 8 and chains them into a 16-bit counter. It checks this chain against a 16-bit reference model. The chain reaches the inter-stage carry path, where the high stage advances only on the low stage's terminal count. It also reaches the full 16-bit wrap points, which are hit on purpose by loading values next to them. A third instance with `WIDTH` = 3 runs from the same stimulus. Its wraps and its carry come around every few cycles, so random traffic exercises the parametric terminal values often.

// File: rtl/updn_ctr_pkg.sv
package updn_ctr_pkg;
  typedef enum logic [1:0] {
    OP_CLR  = 2'b00,
    OP_DOWN = 2'b01,
    OP_LOAD = 2'b10,
    OP_UP   = 2'b11
  } ctr_op_e;
endpackage

// File: rtl/updn_op_decode.sv
module updn_op_decode
  import updn_ctr_pkg::*;
(
  input  logic [1:0] op_sel,
  input  logic       en_par_n,
  input  logic       en_trk_n,
  output logic       is_clear,
  output logic       is_load,
  output logic       is_up_mode,
  output logic       is_dn_mode,
  output logic       do_step
);
  ctr_op_e op;
  logic    enabled;

  always_comb begin
    op         = ctr_op_e'(op_sel);
    is_clear   = (op == OP_CLR);
    is_load    = (op == OP_LOAD);
    is_up_mode = (op == OP_UP);
    is_dn_mode = (op == OP_DOWN);
    enabled    = ~en_par_n & ~en_trk_n;
    do_step    = enabled & (is_up_mode | is_dn_mode);
  end
endmodule

// File: rtl/updn_carry_gen.sv
module updn_carry_gen #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] count_q,
  input  logic             is_up_mode,
  input  logic             is_dn_mode,
  input  logic             en_trk_n,
  output logic             at_terminal,
  output logic             carry_n
);
  logic all_ones;
  logic all_zero;

  always_comb begin
    all_ones    = &count_q;
    all_zero    = ~|count_q;
    at_terminal = (is_up_mode & all_ones) | (is_dn_mode & all_zero);
    carry_n     = ~(at_terminal & ~en_trk_n);
  end
endmodule

// File: rtl/updn_state_reg.sv
module updn_state_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_clear,
  input  logic             is_load,
  input  logic             is_up_mode,
  input  logic             do_step,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] count_q
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  function automatic logic [WIDTH-1:0] next_count(
    input logic [WIDTH-1:0] cur,
    input logic             clr,
    input logic             ld,
    input logic             up,
    input logic             stp,
    input logic [WIDTH-1:0] dv
  );
    if (clr)      return '0;
    else if (ld)  return dv;
    else if (stp) return up ? cur + ONE : cur - ONE;
    else          return cur;
  endfunction

  logic [WIDTH-1:0] count_d;

  always_comb count_d = next_count(count_q, is_clear, is_load, is_up_mode, do_step, load_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end
endmodule

// File: rtl/updn_cascade_ctr.sv
module updn_cascade_ctr #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       op_sel,
  input  logic             en_par_n,
  input  logic             en_trk_n,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] count_q,
  output logic             carry_n
);
  localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};

  logic is_clear, is_load, is_up_mode, is_dn_mode, do_step;
  logic at_terminal;

  updn_op_decode u_dec (
    .op_sel     (op_sel),
    .en_par_n   (en_par_n),
    .en_trk_n   (en_trk_n),
    .is_clear   (is_clear),
    .is_load    (is_load),
    .is_up_mode (is_up_mode),
    .is_dn_mode (is_dn_mode),
    .do_step    (do_step)
  );

  updn_state_reg #(.WIDTH(WIDTH)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .is_clear   (is_clear),
    .is_load    (is_load),
    .is_up_mode (is_up_mode),
    .do_step    (do_step),
    .load_val   (load_val),
    .count_q    (count_q)
  );

  updn_carry_gen #(.WIDTH(WIDTH)) u_carry (
    .count_q     (count_q),
    .is_up_mode  (is_up_mode),
    .is_dn_mode  (is_dn_mode),
    .en_trk_n    (en_trk_n),
    .at_terminal (at_terminal),
    .carry_n     (carry_n)
  );

  // R2: clear lands on the following edge
  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b00) |=> (count_q == '0));

  // R3: load captures the data word
  a_r3_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b10) |=> (count_q == $past(load_val)));

  // R4: up count with wrap
  a_r4_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b11 && !en_par_n && !en_trk_n) |=> (count_q == $past(count_q) + WIDTH'(1)));

  // R5: down count with wrap
  a_r5_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b01 && !en_par_n && !en_trk_n) |=> (count_q == $past(count_q) - WIDTH'(1)));

  // R6: hold when an enable is high in a count mode
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel[0] && (en_par_n || en_trk_n)) |=> $stable(count_q));

  // R7: trickle enable high forces the carry high
  a_r7_trk_blocks_carry: assert property (@(posedge clk) disable iff (!rst_n)
    en_trk_n |-> carry_n);

  // R7: terminal count up with trickle low pulls the carry low
  a_r7_up_terminal: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b11 && !en_trk_n && count_q == TOP_VAL) |-> !carry_n);
endmodule

// File: tb/sim_updn_cascade_ctr.sv
`timescale 1ns/1ps
module sim_updn_cascade_ctr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic        en_par_n = 1'b1;
  logic        en_trk_n = 1'b1;
  logic [15:0] load_val = '0;
  logic [7:0]  q_lo, q_hi;
  logic [2:0]  q_nar;
  logic        c_lo_n, c_hi_n, c_nar_n;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] ref16 = '0;
  logic [2:0]  ref3 = '0;

  always #2 clk = ~clk;

  updn_cascade_ctr #(.WIDTH(8)) u0 (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .en_par_n(en_par_n),
    .en_trk_n(en_trk_n), .load_val(load_val[7:0]), .count_q(q_lo), .carry_n(c_lo_n));

  updn_cascade_ctr #(.WIDTH(8)) u1 (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .en_par_n(en_par_n),
    .en_trk_n(c_lo_n), .load_val(load_val[15:8]), .count_q(q_hi), .carry_n(c_hi_n));

  updn_cascade_ctr #(.WIDTH(3)) u2 (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .en_par_n(en_par_n),
    .en_trk_n(en_trk_n), .load_val(load_val[2:0]), .count_q(q_nar), .carry_n(c_nar_n));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_next(input logic [31:0] v, input int w,
      input logic [1:0] op, input logic par_n, input logic trk_n, input logic [31:0] d);
    logic [31:0] mask;
    mask = (32'd1 << w) - 32'd1;
    case (op)
      2'b00: return 32'd0;
      2'b10: return d & mask;
      2'b11: return (par_n | trk_n) ? v : ((v + 32'd1) & mask);
      default: return (par_n | trk_n) ? v : ((v + mask) & mask);
    endcase
  endfunction

  function automatic logic model_carry(input logic [31:0] v, input int w,
      input logic [1:0] op, input logic trk_n);
    logic [31:0] mask;
    mask = (32'd1 << w) - 32'd1;
    if (trk_n) return 1'b1;
    if (op == 2'b01 && v == 32'd0) return 1'b0;
    if (op == 2'b11 && v == mask) return 1'b0;
    return 1'b1;
  endfunction

  // One cycle: drive at the falling edge, check the carries and the held count, then update the model at the rising edge
  task automatic cycle(input logic [1:0] op, input logic par_n, input logic trk_n, input logic [15:0] d);
    @(negedge clk);
    check("R9 chain count", {16'h0, q_hi, q_lo}, {16'h0, ref16});
    check("R10 narrow count", {29'h0, q_nar}, {29'h0, ref3});
    op_sel = op; en_par_n = par_n; en_trk_n = trk_n; load_val = d;
    #1;
    check("R8 count held between edges", {16'h0, q_hi, q_lo}, {16'h0, ref16});
    check("R7 chain carry", {31'h0, c_hi_n}, {31'h0, model_carry({16'h0, ref16}, 16, op, trk_n)});
    check("R7 stage carry", {31'h0, c_lo_n}, {31'h0, model_carry({24'h0, ref16[7:0]}, 8, op, trk_n)});
    check("R10 narrow carry", {31'h0, c_nar_n}, {31'h0, model_carry({29'h0, ref3}, 3, op, trk_n)});
    @(posedge clk);
    ref16 = model_next({16'h0, ref16}, 16, op, par_n, trk_n, {16'h0, d})[15:0];
    ref3  = model_next({29'h0, ref3}, 3, op, par_n, trk_n, {16'h0, d})[2:0];
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R1 reset count", {16'h0, q_hi, q_lo}, 32'h0);
    check("R1 reset narrow", {29'h0, q_nar}, 32'h0);
    rst_n = 1'b1;

    // R3 load with enables high, R4 cascade carry at 00FF
    cycle(2'b10, 1'b1, 1'b1, 16'h00FD);
    for (int i = 0; i < 5; i++) cycle(2'b11, 1'b0, 1'b0, 16'h0);
    // R6 hold via each enable at a terminal value
    cycle(2'b10, 1'b0, 1'b0, 16'hFFFF);
    cycle(2'b11, 1'b1, 1'b0, 16'h0);
    cycle(2'b11, 1'b0, 1'b1, 16'h0);
    // R4 wrap up
    cycle(2'b11, 1'b0, 1'b0, 16'h0);
    cycle(2'b11, 1'b0, 1'b0, 16'h0);
    // R5 wrap down and borrow across the stages
    cycle(2'b01, 1'b0, 1'b0, 16'h0);
    cycle(2'b01, 1'b0, 1'b0, 16'h0);
    cycle(2'b10, 1'b1, 1'b0, 16'h0101);
    for (int i = 0; i < 4; i++) cycle(2'b01, 1'b0, 1'b0, 16'h0);
    // R2 clear with enables high, carry high in clear/load modes
    cycle(2'b00, 1'b1, 1'b1, 16'h1234);
    cycle(2'b00, 1'b0, 1'b0, 16'h0);
    cycle(2'b10, 1'b0, 1'b0, 16'hFFFF);
    cycle(2'b10, 1'b0, 1'b0, 16'h0000);

    for (int i = 0; i < 4000; i++) begin
      logic [1:0]  op;
      logic [15:0] d;
      int r;
      r = $urandom_range(0, 99);
      op = (r < 3) ? 2'b00 : (r < 8) ? 2'b10 : (r < 54) ? 2'b11 : 2'b01;
      d = ($urandom_range(0, 3) == 0) ? ({$urandom_range(0, 1) == 1 ? 8'hFF : 8'h00, 8'hFE} ^ 16'($urandom_range(0, 3)))
                                      : 16'($urandom);
      cycle(op, $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0, d);
    end
    @(negedge clk);
    check("R9 final chain count", {16'h0, q_hi, q_lo}, {16'h0, ref16});
    report();
  end
endmodule